// File: doc/BRIEF.md
# Split Segment Address Translator

This block maps logical addresses to physical addresses for a processor that uses segment relocation instead of paging. It holds two relocation segments: one for instruction fetch and one for loads and stores. Each segment has a base and a length. An address on the fetch port is checked against the program segment and relocated by it. An address on the data port uses the data segment in the same way. Both ports work combinationally, so the result comes back in the same cycle as the request.

The four segment registers sit behind a small configuration port. That port honours reads and writes only while the processor reports kernel privilege. A write attempted in user mode has no effect, and a one-cycle error pulse reports it. After reset every register is zero, so each access faults until the kernel programs the segments. When an access faults, its physical address is driven to zero and its grant is withheld, so nothing reaches memory.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset all four segment registers read as zero, `cfg_priv_err` is low, and any request on either port faults.
- R2: For a legal request the physical address equals (zero-extended logical address + base) modulo 2^PA_W. `*_ok` is high and `*_fault` is low in the same cycle as the request.
- R3: A request is legal only when its logical address is strictly below the segment length. An illegal request raises `*_fault`, holds `*_ok` low and drives `*_pa` to zero.
- R4: When a port's request input is low, that port drives `*_ok` low, `*_fault` low and `*_pa` to zero.
- R5: The fetch port uses only the program segment and the data port uses only the data segment. `cfg_sel` encoding: 0 = program base, 1 = program length, 2 = data base, 3 = data length.
- R6: A write with `cfg_we` high and `priv_kernel` high loads `cfg_wdata` into the selected register, and the new value takes effect from the next clock cycle.
- R7: A write with `priv_kernel` low changes no register. `cfg_priv_err` is high in the cycle after each such attempt and low otherwise.
- R8: `cfg_rdata` returns the selected register while `priv_kernel` is high, and zero while it is low.
- R9: The limit is exact: the address length−1 is legal and the address equal to the length faults. This holds at the top length values as well, and for a base large enough that the sum wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_kernel | input | 1 | 1 = processor in kernel mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | PA_W | Write data |
| cfg_rdata | output | PA_W | Read data (zero in user mode) |
| cfg_priv_err | output | 1 | Pulse after a user-mode write attempt |
| fetch_req | input | 1 | Fetch request |
| fetch_la | input | LA_W | Fetch logical address |
| fetch_pa | output | PA_W | Fetch physical address |
| fetch_ok | output | 1 | Fetch granted |
| fetch_fault | output | 1 | Fetch out of bounds |
| data_req | input | 1 | Load/store request |
| data_la | input | LA_W | Data logical address |
| data_pa | output | PA_W | Data physical address |
| data_ok | output | 1 | Data access granted |
| data_fault | output | 1 | Data access out of bounds |

## Verification
The bench sweeps every logical address on both ports under several segment settings. This exposes an off-by-one limit, which would grant or fault the address equal to the length, and it exposes swapped segments, which would relocate fetches with the data base. One setting uses a base near the top of the physical range, so a design that saturates or widens the sum gives the wrong address. User-mode writes are followed by kernel read-back and by fresh translations; a design that leaks the write would show a changed segment. The bench also checks the error pulse, which a broken design would drop or stretch.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned NUM_SEG_REGS = 4;
  localparam int unsigned SEL_W        = $clog2(NUM_SEG_REGS);

  typedef enum logic [SEL_W-1:0] {
    SEL_PROG_BASE = 2'd0,
    SEL_PROG_LEN  = 2'd1,
    SEL_DATA_BASE = 2'd2,
    SEL_DATA_LEN  = 2'd3
  } seg_sel_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PA_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_kernel,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [PA_W-1:0]  cfg_wdata,
  output logic [PA_W-1:0]  cfg_rdata,
  output logic             cfg_priv_err,
  output logic [PA_W-1:0]  prog_base,
  output logic [PA_W-1:0]  prog_len,
  output logic [PA_W-1:0]  data_base,
  output logic [PA_W-1:0]  data_len
);
  logic [PA_W-1:0] regs_q [NUM_SEG_REGS];
  logic [PA_W-1:0] regs_d [NUM_SEG_REGS];
  logic            wr_en;
  logic            err_d, err_q;

  assign wr_en = cfg_we & priv_kernel;
  assign err_d = cfg_we & ~priv_kernel;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SEG_REGS; gi++) begin : g_reg
      always_comb begin
        regs_d[gi] = regs_q[gi];
        if (wr_en && (cfg_sel == SEL_W'(gi))) regs_d[gi] = cfg_wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[gi] <= '0;
        else        regs_q[gi] <= regs_d[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign cfg_rdata    = priv_kernel ? regs_q[cfg_sel] : '0;
  assign cfg_priv_err = err_q;
  assign prog_base    = regs_q[SEL_PROG_BASE];
  assign prog_len     = regs_q[SEL_PROG_LEN];
  assign data_base    = regs_q[SEL_DATA_BASE];
  assign data_len     = regs_q[SEL_DATA_LEN];
endmodule

// File: rtl/seg_xlate_port.sv
module seg_xlate_port #(
  parameter int unsigned LA_W = 12,
  parameter int unsigned PA_W = 16
) (
  input  logic            req,
  input  logic [LA_W-1:0] la,
  input  logic [PA_W-1:0] base,
  input  logic [PA_W-1:0] len,
  output logic [PA_W-1:0] pa,
  output logic            ok,
  output logic            fault
);
  logic [PA_W-1:0] la_ext;
  logic [PA_W-1:0] sum;
  logic            in_seg;

  assign la_ext = PA_W'(la);
  assign sum    = la_ext + base;
  assign in_seg = la_ext < len;

  always_comb begin
    ok    = req & in_seg;
    fault = req & ~in_seg;
    pa    = ok ? sum : '0;
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int unsigned LA_W = 12,
  parameter int unsigned PA_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_kernel,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [PA_W-1:0]  cfg_wdata,
  output logic [PA_W-1:0]  cfg_rdata,
  output logic             cfg_priv_err,
  input  logic             fetch_req,
  input  logic [LA_W-1:0]  fetch_la,
  output logic [PA_W-1:0]  fetch_pa,
  output logic             fetch_ok,
  output logic             fetch_fault,
  input  logic             data_req,
  input  logic [LA_W-1:0]  data_la,
  output logic [PA_W-1:0]  data_pa,
  output logic             data_ok,
  output logic             data_fault
);
  logic            rst_s1, rst_s2;
  logic [PA_W-1:0] prog_base, prog_len, data_base, data_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  seg_regfile #(.PA_W(PA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_s2),
    .priv_kernel  (priv_kernel),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .cfg_priv_err (cfg_priv_err),
    .prog_base    (prog_base),
    .prog_len     (prog_len),
    .data_base    (data_base),
    .data_len     (data_len)
  );

  seg_xlate_port #(.LA_W(LA_W), .PA_W(PA_W)) u_fetch (
    .req   (fetch_req),
    .la    (fetch_la),
    .base  (prog_base),
    .len   (prog_len),
    .pa    (fetch_pa),
    .ok    (fetch_ok),
    .fault (fetch_fault)
  );

  seg_xlate_port #(.LA_W(LA_W), .PA_W(PA_W)) u_data (
    .req   (data_req),
    .la    (data_la),
    .base  (data_base),
    .len   (data_len),
    .pa    (data_pa),
    .ok    (data_ok),
    .fault (data_fault)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned PA_W = 16
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            priv_kernel,
  input logic            cfg_we,
  input logic            cfg_priv_err,
  input logic            fetch_req,
  input logic            fetch_ok,
  input logic            fetch_fault,
  input logic [PA_W-1:0] fetch_pa,
  input logic            data_req,
  input logic            data_ok,
  input logic            data_fault,
  input logic [PA_W-1:0] data_pa,
  input logic [PA_W-1:0] prog_base,
  input logic [PA_W-1:0] prog_len,
  input logic [PA_W-1:0] data_base,
  input logic [PA_W-1:0] data_len
);
  // R3: a faulting access never exposes an address
  a_r3_fetch_fault_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_fault |-> (fetch_pa == '0 && !fetch_ok));
  a_r3_data_fault_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_fault |-> (data_pa == '0 && !data_ok));

  // R4: no request, no response
  a_r4_fetch_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fetch_req |-> (!fetch_ok && !fetch_fault && fetch_pa == '0));
  a_r4_data_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !data_req |-> (!data_ok && !data_fault && data_pa == '0));

  // R2: a request is answered in the same cycle by exactly one of grant/fault
  a_r2_fetch_answered: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_req |-> $onehot({fetch_ok, fetch_fault}));
  a_r2_data_answered: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_req |-> $onehot({data_ok, data_fault}));

  // R7: user-mode write leaves every segment register unchanged and raises the pulse
  a_r7_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && !priv_kernel) |=> ($stable(prog_base) && $stable(prog_len) &&
                                  $stable(data_base) && $stable(data_len)));
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && !priv_kernel) |=> cfg_priv_err);
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cfg_we && !priv_kernel) |=> !cfg_priv_err);
endmodule

bind seg_xlate_top seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_s2),
  .priv_kernel  (priv_kernel),
  .cfg_we       (cfg_we),
  .cfg_priv_err (cfg_priv_err),
  .fetch_req    (fetch_req),
  .fetch_ok     (fetch_ok),
  .fetch_fault  (fetch_fault),
  .fetch_pa     (fetch_pa),
  .data_req     (data_req),
  .data_ok      (data_ok),
  .data_fault   (data_fault),
  .data_pa      (data_pa),
  .prog_base    (prog_base),
  .prog_len     (prog_len),
  .data_base    (data_base),
  .data_len     (data_len)
);

// File: tb/tb_seg_xlate_top.sv
module tb_seg_xlate_top;
  localparam int LA_W = 4;
  localparam int PA_W = 5;
  localparam int PMOD = 1 << PA_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            priv_kernel = 1'b1;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_sel = '0;
  logic [PA_W-1:0] cfg_wdata = '0;
  logic [PA_W-1:0] cfg_rdata;
  logic            cfg_priv_err;
  logic            fetch_req = 1'b0;
  logic [LA_W-1:0] fetch_la = '0;
  logic [PA_W-1:0] fetch_pa;
  logic            fetch_ok, fetch_fault;
  logic            data_req = 1'b0;
  logic [LA_W-1:0] data_la = '0;
  logic [PA_W-1:0] data_pa;
  logic            data_ok, data_fault;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_xlate_top #(.LA_W(LA_W), .PA_W(PA_W)) dut (
    .clk(clk), .rst_n(rst_n), .priv_kernel(priv_kernel),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_priv_err(cfg_priv_err),
    .fetch_req(fetch_req), .fetch_la(fetch_la), .fetch_pa(fetch_pa),
    .fetch_ok(fetch_ok), .fetch_fault(fetch_fault),
    .data_req(data_req), .data_la(data_la), .data_pa(data_pa),
    .data_ok(data_ok), .data_fault(data_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int val, input bit kern);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = PA_W'(val); priv_kernel = kern;
    @(negedge clk);
    cfg_we = 1'b0; priv_kernel = 1'b1;
    #1;
    chk(kern ? "R6 no err pulse on kernel write" : "R7 err pulse after user write",
        int'(cfg_priv_err), kern ? 0 : 1);
  endtask

  task automatic read_check(input int sel, input int exp, input string tag);
    @(negedge clk);
    priv_kernel = 1'b1; cfg_sel = 2'(sel);
    #1;
    chk(tag, int'(cfg_rdata), exp);
  endtask

  // R2 R3 R5 R9: sweep every logical address on both ports
  task automatic sweep(input int pb, input int pl, input int db, input int dl);
    for (int la = 0; la < (1 << LA_W); la++) begin
      @(negedge clk);
      fetch_req = 1'b1; fetch_la = LA_W'(la);
      data_req  = 1'b1; data_la  = LA_W'((1 << LA_W) - 1 - la);
      #1;
      begin
        int dla = (1 << LA_W) - 1 - la;
        bit fleg = la < pl;
        bit dleg = dla < dl;
        chk("R3 R5 fetch ok", int'(fetch_ok), int'(fleg));
        chk("R3 R9 fetch fault", int'(fetch_fault), int'(!fleg));
        chk("R2 R5 fetch pa", int'(fetch_pa), fleg ? (la + pb) % PMOD : 0);
        chk("R3 R5 data ok", int'(data_ok), int'(dleg));
        chk("R3 R9 data fault", int'(data_fault), int'(!dleg));
        chk("R2 R5 data pa", int'(data_pa), dleg ? (dla + db) % PMOD : 0);
      end
    end
    @(negedge clk);
    fetch_req = 1'b0; data_req = 1'b0; fetch_la = '1; data_la = '0;
    #1;
    chk("R4 fetch idle", int'({fetch_ok, fetch_fault}) + int'(fetch_pa), 0);
    chk("R4 data idle", int'({data_ok, data_fault}) + int'(data_pa), 0);
  endtask

  task automatic program_all(input int pb, input int pl, input int db, input int dl);
    cfg_write(0, pb, 1'b1);
    cfg_write(1, pl, 1'b1);
    cfg_write(2, db, 1'b1);
    cfg_write(3, dl, 1'b1);
    read_check(0, pb, "R8 R6 read prog base");
    read_check(1, pl, "R8 R6 read prog len");
    read_check(2, db, "R8 R6 read data base");
    read_check(3, dl, "R8 R6 read data len");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 4; s++) read_check(s, 0, "R1 register reset value");
    chk("R1 err low after reset", int'(cfg_priv_err), 0);
    sweep(0, 0, 0, 0);

    // R2 R3 R5 R9: distinct segment settings
    program_all(3, 7, 20, 12);
    sweep(3, 7, 20, 12);
    program_all(30, 31, 1, 16);          // wrap on fetch, full window on data
    sweep(30, 31, 1, 16);
    program_all(0, 16, 31, 1);           // length == address span; single-address data
    sweep(0, 16, 31, 1);

    // R7: user-mode writes change nothing
    cfg_write(0, 9, 1'b0);
    @(negedge clk);
    chk("R7 err pulse lasts one cycle", int'(cfg_priv_err), 0);
    cfg_write(1, 2, 1'b0);
    cfg_write(2, 5, 1'b0);
    cfg_write(3, 0, 1'b0);
    read_check(0, 0,  "R7 prog base kept");
    read_check(1, 16, "R7 prog len kept");
    read_check(2, 31, "R7 data base kept");
    read_check(3, 1,  "R7 data len kept");
    sweep(0, 16, 31, 1);

    // R8: user-mode reads return zero
    @(negedge clk);
    priv_kernel = 1'b0; cfg_sel = 2'd2;
    #1;
    chk("R8 user read zero", int'(cfg_rdata), 0);
    @(negedge clk);
    priv_kernel = 1'b1;
    #1;
    chk("R8 kernel read same reg", int'(cfg_rdata), 31);

    // R6: the new length takes effect the cycle after the write
    @(negedge clk);
    fetch_req = 1'b1; fetch_la = 4'd5;
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 5'd5;
    #1;
    chk("R6 old length still in force", int'(fetch_ok), 1);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R6 new length in force", int'(fetch_fault), 1);
    fetch_req = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule